// File: doc/BRIEF.md
# Ranked Interrupt Winner Resolver

This block works out which active interrupt source has the best rank. It does this separately for the normal class and for the fast class. Rank comes from a programmable table, not from the source number. Each table slot names one source ID and carries a valid flag. A slot with a lower index outranks every slot with a higher index.

On each start pulse, the resolver walks the table one slot per clock. A source counts as a candidate when its bit in the active vector is set. The active vector is the AND of pending and enabled, formed outside this block. A set bit in the class vector sends the source to the fast group; a clear bit sends it to the normal group.

When the walk ends, the two winners are packed into a 32-bit status word, which the register port reads as is. The word then holds until the next walk completes.

Top module: `pri_resolver`

## Requirements
- R1: After reset, `status` is 0x003F003F and both `busy` and `done` are 0.
- R2: When `start` is sampled high, `busy` is 1 and `done` is 0 after that edge. Exactly `N_SRC` edges after the start edge, `done` becomes 1 and `busy` becomes 0. `done` then stays 1 until the next start.
- R3: Slot k of `prio_tbl` occupies bits [7k+6:7k]. Bit 7k+6 is the valid flag and bits [7k+5:7k] are the source ID. A slot is skipped when its flag is 0 or its ID is `N_SRC` or more.
- R4: A source is a candidate only when its bit in `act_vec` is 1. Its bit in `cls_vec` picks the group: 1 for fast, 0 for normal.
- R5: Within each group, the candidate in the smallest-indexed usable slot wins. The two groups resolve independently. When an ID appears in several slots, the lowest of them decides its rank.
- R6: A normal winner sets `status[31]` and places its ID in `status[21:16]`.
- R7: A fast winner sets `status[15]` and places its ID in `status[5:0]`.
- R8: A group with no winner shows flag 0 and ID field 0x3F. Bits [30:22] and [14:6] are always 0.
- R9: `status` changes only on the edge where `done` rises. A start during a walk abandons that walk and restarts it from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a table walk |
| prio_tbl | input | 7*N_SRC | Rank table; slot k holds {valid, id[5:0]} |
| act_vec | input | N_SRC | Pending-and-enabled source bits |
| cls_vec | input | N_SRC | Class per source, 1 = fast |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Last walk finished; status is current |
| status | output | 32 | Packed winners of both classes |

## Verification
The bench covers the cases a walk can get wrong:
- **Two active candidates in one group.** A design that compared slots in the wrong direction would report the later slot.
- **A slot whose ID is out of range.** A design that forgot the range check would read a non-existent source bit.
- **A slot with its flag cleared.** A design that ignored the flag would let that slot win.
- **A winner in the very last slot.** A design off by one in its end count would drop it, or raise `done` a cycle early or late.
- **A restart in the middle of a walk.** A design that kept stale winners would report the first walk's source instead of the second's.

The bench also checks that `status` holds its old value while a walk is running. Publishing partial results would show up as a mismatch there.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int PR_ID_W    = 6;
  localparam int PR_ENT_W   = PR_ID_W + 1;
  localparam int PR_STAT_W  = 32;
  localparam int PR_NORM_FLAG = 31;
  localparam int PR_NORM_LSB  = 16;
  localparam int PR_FAST_FLAG = 15;
  localparam int PR_FAST_LSB  = 0;
  localparam logic [PR_ID_W-1:0] PR_NONE_ID = '1;

  typedef struct packed {
    logic               vld;
    logic [PR_ID_W-1:0] id;
  } pr_entry_t;

  typedef struct packed {
    logic               vld;
    logic [PR_ID_W-1:0] id;
  } pr_win_t;

  function automatic logic [PR_STAT_W-1:0] pr_pack(pr_win_t nrm, pr_win_t fst);
    logic [PR_STAT_W-1:0] w;
    w = '0;
    w[PR_NORM_FLAG] = nrm.vld;
    w[PR_NORM_LSB +: PR_ID_W] = nrm.vld ? nrm.id : PR_NONE_ID;
    w[PR_FAST_FLAG] = fst.vld;
    w[PR_FAST_LSB +: PR_ID_W] = fst.vld ? fst.id : PR_NONE_ID;
    return w;
  endfunction
endpackage

// File: rtl/pr_scan_ctrl.sv
module pr_scan_ctrl #(
  parameter int N_SRC = 40,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] idx,
  output logic          last
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_SRC - 1);

  assign last = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        done <= 1'b1;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pr_entry_qual.sv
module pr_entry_qual
  import pr_pkg::*;
#(
  parameter int N_SRC = 40
) (
  input  pr_entry_t        ent,
  input  logic [N_SRC-1:0] act_vec,
  input  logic [N_SRC-1:0] cls_vec,
  output logic             hit_norm,
  output logic             hit_fast
);
  logic [N_SRC-1:0] sel;
  logic             act_bit;
  logic             cls_bit;

  // One-hot select of the named source; an ID at or past N_SRC selects nothing.
  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    assign sel[i] = (ent.id == PR_ID_W'(i));
  end

  assign act_bit  = |(sel & act_vec);
  assign cls_bit  = |(sel & cls_vec);
  assign hit_norm = ent.vld && act_bit && !cls_bit;
  assign hit_fast = ent.vld && act_bit &&  cls_bit;
endmodule

// File: rtl/pr_win_slot.sv
module pr_win_slot
  import pr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               hit,
  input  logic [PR_ID_W-1:0] id_in,
  output pr_win_t            cur,
  output pr_win_t            nxt
);
  // First hit of a walk wins, since slots are visited in rank order.
  always_comb begin
    nxt = cur;
    if (hit && !cur.vld) begin
      nxt.vld = 1'b1;
      nxt.id  = id_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur.vld <= 1'b0;
      cur.id  <= PR_NONE_ID;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/pri_resolver.sv
module pri_resolver
  import pr_pkg::*;
#(
  parameter int N_SRC = 40,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [N_SRC*PR_ENT_W-1:0] prio_tbl,
  input  logic [N_SRC-1:0]        act_vec,
  input  logic [N_SRC-1:0]        cls_vec,
  output logic                    busy,
  output logic                    done,
  output logic [PR_STAT_W-1:0]    status
);
  logic          scan_last;
  logic [IW-1:0] scan_idx;
  pr_entry_t     cur_ent;
  logic          q_norm, q_fast;
  logic [1:0]    hit;
  pr_win_t       win_cur [2];
  pr_win_t       win_nxt [2];
  logic [PR_STAT_W-1:0] status_q;

  pr_scan_ctrl #(.N_SRC(N_SRC)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done),
    .idx  (scan_idx),
    .last (scan_last)
  );

  assign cur_ent = prio_tbl[scan_idx*PR_ENT_W +: PR_ENT_W];

  pr_entry_qual #(.N_SRC(N_SRC)) u_qual (
    .ent     (cur_ent),
    .act_vec (act_vec),
    .cls_vec (cls_vec),
    .hit_norm(q_norm),
    .hit_fast(q_fast)
  );

  // Index 0 tracks the normal class, index 1 the fast class.
  assign hit[0] = busy && q_norm;
  assign hit[1] = busy && q_fast;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    pr_win_slot u_slot (
      .clk  (clk),
      .rst  (rst),
      .clr  (start),
      .hit  (hit[c]),
      .id_in(cur_ent.id),
      .cur  (win_cur[c]),
      .nxt  (win_nxt[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= pr_pack('{vld: 1'b0, id: PR_NONE_ID}, '{vld: 1'b0, id: PR_NONE_ID});
    end else if (scan_last && !start) begin
      status_q <= pr_pack(win_nxt[0], win_nxt[1]);
    end
  end

  assign status = status_q;
endmodule

// File: rtl/pri_resolver_chk.sv
module pri_resolver_chk #(
  parameter int N_SRC = 40,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [31:0]   status,
  input logic [IW-1:0] scan_idx
);
  // R2: a sampled start begins a walk
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done));

  // R2: done follows the final slot
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && scan_idx == IW'(N_SRC - 1)) |=> (done && !busy));

  // R2: the two handshake levels never overlap
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R8: unused status bits stay zero
  p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (status[30:22] == '0) && (status[14:6] == '0));

  // R8: a class without winner shows the all-ones ID
  p_norm_none_r8: assert property (@(posedge clk) disable iff (rst)
    !status[31] |-> (status[21:16] == 6'h3F));

  p_fast_none_r8: assert property (@(posedge clk) disable iff (rst)
    !status[15] |-> (status[5:0] == 6'h3F));

  // R9: status moves only together with a rising done
  p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(status));
endmodule

bind pri_resolver pri_resolver_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .status  (status),
  .scan_idx(scan_idx)
);

// File: tb/test_pri_resolver.sv
`timescale 1ns/1ps
module test_pri_resolver;
  localparam int N   = 40;
  localparam int EW  = 7;
  localparam int VW  = 164;
  localparam int NV  = 8;

  function automatic logic [12:0] mk(int slot, bit v, int id);
    return {6'(slot), v, 6'(id)};
  endfunction

  localparam logic [12:0] NO = 13'h1F80; // slot 63: not applied
  localparam logic [39:0] ONES = '1;

  // {e0, e1, e2, e3, act, cls, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {NO, NO, NO, NO, ONES, 40'd0, 32'h003F003F},
    {mk(0,1,5), NO, NO, NO, 40'd1 << 5, 40'd0, 32'h8005003F},
    {mk(0,1,7), NO, NO, NO, 40'd1 << 7, 40'd1 << 7, 32'h003F8007},
    {mk(2,1,3), mk(1,1,9), NO, NO, (40'd1 << 3) | (40'd1 << 9), 40'd0, 32'h8009003F},
    {mk(5,1,39), mk(10,1,0), mk(3,1,20), NO, (40'd1 << 39) | 40'd1, 40'd1 << 39, 32'h80008027},
    {mk(0,1,45), mk(1,0,4), mk(2,1,4), NO, ONES, 40'd1 << 4, 32'h003F8004},
    {mk(0,1,12), mk(4,1,12), mk(2,1,30), NO, (40'd1 << 12) | (40'd1 << 30), 40'd0, 32'h800C003F},
    {mk(39,1,1), NO, NO, NO, 40'd1 << 1, 40'd1 << 1, 32'h003F8001}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N*EW-1:0] prio_tbl = '0;
  logic [N-1:0]  act_vec = '0;
  logic [N-1:0]  cls_vec = '0;
  logic          busy, done;
  logic [31:0]   status;

  int checks = 0;
  int errors = 0;
  logic [31:0] prev;

  always #2.5 clk = ~clk;

  pri_resolver #(.N_SRC(N)) i_pri_resolver (
    .clk(clk), .rst(rst), .start(start), .prio_tbl(prio_tbl),
    .act_vec(act_vec), .cls_vec(cls_vec),
    .busy(busy), .done(done), .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int v);
    logic [VW-1:0] w;
    w = VEC[v];
    prio_tbl = '0;
    for (int e = 0; e < 4; e++) begin
      logic [12:0] ent;
      ent = w[VW-1-13*e -: 13];
      if (ent[12:7] < 6'(N)) prio_tbl[int'(ent[12:7])*EW +: EW] = ent[6:0];
    end
    act_vec = w[111:72];
    cls_vec = w[71:32];
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Start edge passed; wait out the walk and check the handshake timing.
  task automatic finish_walk(string tag);
    chk("R2 busy after start", 32'(busy), 32'd1);
    repeat (N - 1) @(negedge clk);
    chk("R2 done not early", 32'(done), 32'd0);
    chk({"R9 status held during walk ", tag}, status, prev);
    @(negedge clk);
    chk("R2 done after last slot", 32'(done), 32'd1);
    chk("R2 busy low at end", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 32'h003F003F);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 via the vector table
    for (int v = 0; v < NV; v++) begin
      prev = status;
      load(v);
      pulse_start();
      finish_walk($sformatf("vec%0d", v));
      chk($sformatf("R5 R6 R7 R8 vector %0d", v), status, VEC[v][31:0]);
    end

    // R2: done stays high until next start
    repeat (5) @(negedge clk);
    chk("R2 done holds", 32'(done), 32'd1);

    // R9: restart mid-walk
    prev = status;
    load(3);
    pulse_start();
    repeat (10) @(negedge clk);
    load(1);
    pulse_start();
    chk("R9 no update on restart", status, prev);
    finish_walk("restart");
    chk("R9 restart result", status, 32'h8005003F);

    // R3: only invalid flags present although all active
    prev = status;
    prio_tbl = '0;
    for (int s = 0; s < N; s++) prio_tbl[s*EW +: EW] = 7'(s % 40);
    act_vec = '1;
    cls_vec = '0;
    pulse_start();
    finish_walk("invalid");
    chk("R3 invalid flags skipped", status, 32'h003F003F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule